// File: doc/BRIEF.md
# Power Mode and Boost Soft-Start Sequencer

This block is the operating-mode controller of a lighting power chip. It walks the chip through five modes: reset, standby, internal startup, boost soft-start and normal. Its inputs are an external active-low reset, a power-on-reset flag, a thermal-fault flag and three control-register bits: standby-bar, boost enable and PFM select. From the mode it derives the enables for the analog bias, the oscillator-ready indication, the register-reset strobe, the converter run enable and the converter PFM/PWM select.

Two timed phases are measured by a tick divider and a millisecond counter. The first phase is the settling wait in internal startup. The second is the soft-start window, during which the converter is forced into PFM. A thermal fault pushes the machine back into startup and holds it there. Clearing standby-bar stops any active mode at once. Every output is a plain level. There is no data stream and no handshake at the edge of the block.

Top module: `pms_mode_seq`

## Requirements
- R1: The mode code on `mode_o` is 0 for reset, 1 for standby, 2 for startup, 3 for boost soft-start and 4 for normal. While `rst_ext_n` is low, or `por_active` was high at the previous clock edge, the mode is reset: `regs_reset` is 1 and every other output is 0. The first clock edge after reset is released moves the mode to standby.
- R2: In standby every output is 0. The mode stays in standby while `stby_n` is low, whatever `boost_en` and `therm_fault` do.
- R3: With `stby_n` high, standby moves to startup at the next edge. In startup `bias_en` is 1 and `osc_ready` is 0. Startup lasts STARTUP_MS*TICK_DIV+1 cycles.
- R4: While `therm_fault` is high in startup, the mode stays in startup and the delay is reloaded; the full delay restarts from the last edge at which the fault was seen. A fault in boost soft-start or normal returns the mode to startup at the next edge, with the converter off.
- R5: When startup completes with `boost_en` high, the mode enters boost soft-start. There `osc_ready`, `boost_run` and `boost_pfm` are all 1, for SOFTSTART_MS*TICK_DIV+1 cycles.
- R6: When soft-start completes, the mode enters normal with `boost_run` at 1. In normal, `boost_pfm` follows `pfm_sel` combinationally (1 = PFM, 0 = PWM).
- R7: `boost_en` low in normal turns `boost_run` off at the next edge while the mode stays normal. `boost_en` low during soft-start ends it at the next edge, entering normal with the converter off.
- R8: `boost_en` high in normal while the converter is off enters boost soft-start at the next edge.
- R9: When startup completes with `boost_en` low, the mode goes straight to normal with `boost_run` at 0.
- R10: `stby_n` low in startup, soft-start or normal moves the mode to standby at the next edge and turns all outputs off. The next startup or soft-start runs its full delay again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_ext_n | input | 1 | External reset, active low, asynchronous assert |
| por_active | input | 1 | Power-on reset flag, sampled synchronously |
| therm_fault | input | 1 | Thermal shutdown event |
| stby_n | input | 1 | Standby-bar control bit (0 = standby) |
| boost_en | input | 1 | Converter enable control bit |
| pfm_sel | input | 1 | Converter mode select after soft-start (1 = PFM) |
| mode_o | output | 3 | Current mode code |
| regs_reset | output | 1 | Forces control registers to defaults |
| bias_en | output | 1 | Reference, bias and oscillator power-up |
| osc_ready | output | 1 | Settling delay finished |
| boost_run | output | 1 | Converter running |
| boost_pfm | output | 1 | Converter in PFM (0 = PWM) |

## Verification
The hardest cases to reach are the ones where a delay must restart from the right edge: a thermal fault released in startup, and standby applied in the middle of soft-start or startup and then lifted. The stimulus first holds the fault far past the delay length, then releases it at a known cycle. It also cancels soft-start ten cycles in and startup twenty cycles in. A scoreboard queue holds each expected mode change with its exact cycle, so a delay that resumes instead of restarting shows up as an off-by-cycles mismatch.

// File: rtl/pms_pkg.sv
package pms_pkg;

  typedef enum logic [2:0] {
    PM_RESET    = 3'd0,
    PM_STANDBY  = 3'd1,
    PM_STARTUP  = 3'd2,
    PM_BOOST_SS = 3'd3,
    PM_NORMAL   = 3'd4
  } pm_mode_e;

  typedef struct packed {
    logic regs_reset;
    logic bias_en;
    logic osc_ready;
    logic boost_run;
    logic boost_pfm;
  } pm_ctl_t;

endpackage

// File: rtl/pms_tick_gen.sv
module pms_tick_gen #(
  parameter int unsigned TICK_DIV = 50000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr_i,
  output logic tick_o
);
  localparam int unsigned PW   = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
  localparam logic [PW-1:0] LAST = PW'(TICK_DIV - 1);

  logic [PW-1:0] pcnt_q;

  assign tick_o = (pcnt_q == LAST) && !clr_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                pcnt_q <= '0;
    else if (clr_i || tick_o)  pcnt_q <= '0;
    else                       pcnt_q <= pcnt_q + 1'b1;
  end

  // R3: the prescaler never runs past its wrap value
  a_r3_prescale_bound: assert property (@(posedge clk) disable iff (!rst_n)
    pcnt_q <= LAST);

endmodule

// File: rtl/pms_delay_timer.sv
module pms_delay_timer #(
  parameter int unsigned CW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr_i,
  input  logic          tick_i,
  input  logic [CW-1:0] limit_i,
  output logic          done_o
);
  logic [CW-1:0] cnt_q;

  assign done_o = (cnt_q == limit_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                   cnt_q <= '0;
    else if (clr_i)               cnt_q <= '0;
    else if (tick_i && !done_o)   cnt_q <= cnt_q + 1'b1;
  end

  // R3: a cleared count restarts from zero at the next edge
  a_r3_clear_restarts: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> (cnt_q == '0));

  // R5: the count moves only on a tick
  a_r5_step_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_i && !tick_i) |=> $stable(cnt_q));

endmodule

// File: rtl/pms_fsm.sv
module pms_fsm
  import pms_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     por_i,
  input  logic     therm_i,
  input  logic     stby_n_i,
  input  logic     boost_en_i,
  input  logic     done_i,
  output pm_mode_e state_o,
  output logic     boost_up_o,
  output logic     tclr_o
);
  pm_mode_e state_q, state_d;
  logic     boost_up_q, boost_up_d;
  logic     active;

  assign active = (state_q == PM_STARTUP) || (state_q == PM_BOOST_SS) ||
                  (state_q == PM_NORMAL);

  always_comb begin
    state_d = state_q;
    if (por_i) begin
      state_d = PM_RESET;
    end else if (active && !stby_n_i) begin
      state_d = PM_STANDBY;
    end else if (active && therm_i) begin
      state_d = PM_STARTUP;
    end else begin
      case (state_q)
        PM_RESET:    state_d = PM_STANDBY;
        PM_STANDBY:  state_d = stby_n_i ? PM_STARTUP : PM_STANDBY;
        PM_STARTUP:  if (done_i) state_d = boost_en_i ? PM_BOOST_SS : PM_NORMAL;
        PM_BOOST_SS: if (!boost_en_i || done_i) state_d = PM_NORMAL;
        PM_NORMAL:   if (boost_en_i && !boost_up_q) state_d = PM_BOOST_SS;
        default:     state_d = PM_RESET;
      endcase
    end
  end

  assign boost_up_d = (state_d == PM_NORMAL) && boost_en_i &&
                      ((state_q == PM_BOOST_SS) ||
                       ((state_q == PM_NORMAL) && boost_up_q));

  assign tclr_o = (state_d != state_q) || ((state_q == PM_STARTUP) && therm_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= PM_RESET;
      boost_up_q <= 1'b0;
    end else begin
      state_q    <= state_d;
      boost_up_q <= boost_up_d;
    end
  end

  assign state_o    = state_q;
  assign boost_up_o = boost_up_q;

  a_r1_por_to_reset: assert property (@(posedge clk) disable iff (!rst_n)
    por_i |=> (state_q == PM_RESET));

  a_r2_standby_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (!por_i && !stby_n_i && (state_q == PM_STANDBY)) |=> (state_q == PM_STANDBY));

  a_r4_fault_to_startup: assert property (@(posedge clk) disable iff (!rst_n)
    (!por_i && stby_n_i && therm_i &&
     ((state_q == PM_BOOST_SS) || (state_q == PM_NORMAL))) |=> (state_q == PM_STARTUP));

  a_r7_boost_drop: assert property (@(posedge clk) disable iff (!rst_n)
    !boost_en_i |=> !boost_up_q);

  a_r8_boost_relaunch: assert property (@(posedge clk) disable iff (!rst_n)
    (!por_i && stby_n_i && !therm_i && boost_en_i && !boost_up_q &&
     (state_q == PM_NORMAL)) |=> (state_q == PM_BOOST_SS));

  a_r10_standby_exit: assert property (@(posedge clk) disable iff (!rst_n)
    (!por_i && !stby_n_i && active) |=> (state_q == PM_STANDBY));

endmodule

// File: rtl/pms_out_decode.sv
module pms_out_decode
  import pms_pkg::*;
(
  input  pm_mode_e state_i,
  input  logic     boost_up_i,
  input  logic     pfm_sel_i,
  output pm_ctl_t  ctl_o
);
  always_comb begin
    ctl_o = '0;
    case (state_i)
      PM_RESET:    ctl_o.regs_reset = 1'b1;
      PM_STARTUP:  ctl_o.bias_en    = 1'b1;
      PM_BOOST_SS: begin
        ctl_o.bias_en   = 1'b1;
        ctl_o.osc_ready = 1'b1;
        ctl_o.boost_run = 1'b1;
        ctl_o.boost_pfm = 1'b1;
      end
      PM_NORMAL: begin
        ctl_o.bias_en   = 1'b1;
        ctl_o.osc_ready = 1'b1;
        ctl_o.boost_run = boost_up_i;
        ctl_o.boost_pfm = boost_up_i && pfm_sel_i;
      end
      default: ctl_o = '0;
    endcase
  end
endmodule

// File: rtl/pms_mode_seq.sv
module pms_mode_seq
  import pms_pkg::*;
#(
  parameter int unsigned TICK_DIV     = 50000,
  parameter int unsigned STARTUP_MS   = 10,
  parameter int unsigned SOFTSTART_MS = 10
) (
  input  logic       clk,
  input  logic       rst_ext_n,
  input  logic       por_active,
  input  logic       therm_fault,
  input  logic       stby_n,
  input  logic       boost_en,
  input  logic       pfm_sel,
  output logic [2:0] mode_o,
  output logic       regs_reset,
  output logic       bias_en,
  output logic       osc_ready,
  output logic       boost_run,
  output logic       boost_pfm
);
  localparam int unsigned MAX_MS = (STARTUP_MS > SOFTSTART_MS) ? STARTUP_MS : SOFTSTART_MS;
  localparam int unsigned CW     = (MAX_MS > 0) ? $clog2(MAX_MS + 1) : 1;

  pm_mode_e      state;
  logic          boost_up;
  logic          tclr;
  logic          tick;
  logic          done;
  logic [CW-1:0] limit;
  pm_ctl_t       ctl;

  assign limit = (state == PM_STARTUP) ? CW'(STARTUP_MS) : CW'(SOFTSTART_MS);

  pms_tick_gen #(.TICK_DIV(TICK_DIV)) u_tick (
    .clk    (clk),
    .rst_n  (rst_ext_n),
    .clr_i  (tclr),
    .tick_o (tick)
  );

  pms_delay_timer #(.CW(CW)) u_timer (
    .clk     (clk),
    .rst_n   (rst_ext_n),
    .clr_i   (tclr),
    .tick_i  (tick),
    .limit_i (limit),
    .done_o  (done)
  );

  pms_fsm u_fsm (
    .clk        (clk),
    .rst_n      (rst_ext_n),
    .por_i      (por_active),
    .therm_i    (therm_fault),
    .stby_n_i   (stby_n),
    .boost_en_i (boost_en),
    .done_i     (done),
    .state_o    (state),
    .boost_up_o (boost_up),
    .tclr_o     (tclr)
  );

  pms_out_decode u_dec (
    .state_i    (state),
    .boost_up_i (boost_up),
    .pfm_sel_i  (pfm_sel),
    .ctl_o      (ctl)
  );

  assign mode_o     = state;
  assign regs_reset = ctl.regs_reset;
  assign bias_en    = ctl.bias_en;
  assign osc_ready  = ctl.osc_ready;
  assign boost_run  = ctl.boost_run;
  assign boost_pfm  = ctl.boost_pfm;

  // R5: soft-start is always entered in PFM with the converter running
  a_r5_ss_entry_pfm: assert property (@(posedge clk) disable iff (!rst_ext_n)
    ($rose(boost_run) && (state == PM_BOOST_SS)) |-> boost_pfm);

  // R9: normal entered straight from startup leaves the converter off
  a_r9_direct_normal: assert property (@(posedge clk) disable iff (!rst_ext_n)
    ($past(state) == PM_STARTUP && state == PM_NORMAL) |-> !boost_run);

endmodule

// File: tb/tb_pms_mode_seq.sv
module tb_pms_mode_seq;
  localparam int unsigned DIV = 4;
  localparam int unsigned SU  = 10;
  localparam int unsigned SS  = 10;
  localparam int unsigned DSU = SU * DIV + 1;
  localparam int unsigned DSS = SS * DIV + 1;

  logic clk = 1'b0;
  logic rst_ext_n, por_active, therm_fault, stby_n, boost_en, pfm_sel;
  logic [2:0] mode_o;
  logic regs_reset, bias_en, osc_ready, boost_run, boost_pfm;

  int unsigned cyc = 0;
  int checks = 0;
  int failures = 0;
  bit mon_en = 1'b0;
  bit done = 1'b0;
  logic [2:0] prev_mode;

  typedef struct {
    logic [2:0]  m;
    int unsigned t;
    string       req;
  } exp_t;
  exp_t q[$];

  pms_mode_seq #(.TICK_DIV(DIV), .STARTUP_MS(SU), .SOFTSTART_MS(SS)) dut (
    .clk(clk), .rst_ext_n(rst_ext_n), .por_active(por_active),
    .therm_fault(therm_fault), .stby_n(stby_n), .boost_en(boost_en),
    .pfm_sel(pfm_sel), .mode_o(mode_o), .regs_reset(regs_reset),
    .bias_en(bias_en), .osc_ready(osc_ready), .boost_run(boost_run),
    .boost_pfm(boost_pfm)
  );

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d cycle=%0d", req, act, exp, cyc);
    end
  endtask

  task automatic push(input logic [2:0] m, input int unsigned t, input string req);
    exp_t e;
    e.m = m; e.t = t; e.req = req;
    q.push_back(e);
  endtask

  task automatic wait_until(input int unsigned t);
    while (cyc < t) @(negedge clk);
  endtask

  // monitor: pops one expected mode change per observed change
  initial begin
    forever begin
      @(posedge clk);
      #5;
      if (mon_en && mode_o !== prev_mode) begin
        if (q.size() == 0) begin
          checks++; failures++;
          $display("FAIL unexpected mode change actual=%0d expected=%0d cycle=%0d",
                   mode_o, prev_mode, cyc);
        end else begin
          exp_t e;
          e = q.pop_front();
          check({e.req, " mode"}, mode_o, e.m);
          check({e.req, " cycle"}, cyc, e.t);
        end
        prev_mode = mode_o;
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int unsigned c, c2;
    rst_ext_n = 1'b0; por_active = 1'b0; therm_fault = 1'b0;
    stby_n = 1'b0; boost_en = 1'b0; pfm_sel = 1'b0;
    repeat (3) @(negedge clk);
    check("R1 reset mode", mode_o, 0);
    check("R1 regs_reset", regs_reset, 1);
    check("R1 others off", {bias_en, osc_ready, boost_run, boost_pfm}, 0);
    prev_mode = 3'd0; mon_en = 1'b1;

    // release reset -> standby
    c = cyc; rst_ext_n = 1'b1; push(3'd1, c + 1, "R1");
    wait_until(c + 4);
    check("R2 standby outputs", {regs_reset, bias_en, osc_ready, boost_run, boost_pfm}, 0);
    boost_en = 1'b1; therm_fault = 1'b1;
    repeat (5) @(negedge clk);
    check("R2 standby held", mode_o, 1);
    check("R2 bias off", bias_en, 0);
    therm_fault = 1'b0;

    // full power-up with boost soft-start
    c = cyc; stby_n = 1'b1;
    push(3'd2, c + 1, "R3"); push(3'd3, c + 1 + DSU, "R5"); push(3'd4, c + 1 + DSU + DSS, "R6");
    wait_until(c + 2);
    check("R3 bias_en", bias_en, 1);
    check("R3 osc not ready", osc_ready, 0);
    wait_until(c + DSU);
    check("R3 osc still not ready at last startup cycle", osc_ready, 0);
    wait_until(c + 1 + DSU);
    check("R5 osc_ready", osc_ready, 1);
    check("R5 boost_run", boost_run, 1);
    check("R5 boost_pfm", boost_pfm, 1);
    wait_until(c + 1 + DSU + DSS);
    check("R6 pwm after soft-start", boost_pfm, 0);
    check("R6 boost_run", boost_run, 1);

    // pfm select in normal
    pfm_sel = 1'b1; #1;
    check("R6 pfm follows select", boost_pfm, 1);
    @(negedge clk); pfm_sel = 1'b0; #1;
    check("R6 pwm follows select", boost_pfm, 0);

    // converter standby in normal
    @(negedge clk); c = cyc; boost_en = 1'b0;
    wait_until(c + 1);
    check("R7 boost_run off", boost_run, 0);
    check("R7 mode stays normal", mode_o, 4);
    wait_until(c + 3);

    // relaunch soft-start
    c = cyc; boost_en = 1'b1;
    push(3'd3, c + 1, "R8"); push(3'd4, c + 1 + DSS, "R8");
    wait_until(c + 1);
    check("R8 soft-start pfm", boost_pfm, 1);
    wait_until(c + 4 + DSS);

    // thermal fault from normal, held past the delay
    c = cyc; therm_fault = 1'b1; push(3'd2, c + 1, "R4");
    wait_until(c + 1);
    check("R4 converter off", boost_run, 0);
    check("R4 osc not ready", osc_ready, 0);
    wait_until(c + 60);
    check("R4 held in startup", mode_o, 2);
    c2 = cyc; therm_fault = 1'b0;
    push(3'd3, c2 + DSU, "R4"); push(3'd4, c2 + DSU + DSS, "R4");
    wait_until(c2 + DSU - 1);
    check("R4 delay restarted", osc_ready, 0);
    wait_until(c2 + DSU + DSS + 3);

    // standby in mid soft-start, then full delays again
    c = cyc; boost_en = 1'b0;
    wait_until(c + 2);
    c = cyc; boost_en = 1'b1; push(3'd3, c + 1, "R8");
    wait_until(c + 10);
    c = cyc; stby_n = 1'b0; push(3'd1, c + 1, "R10");
    wait_until(c + 1);
    check("R10 converter off", boost_run, 0);
    check("R10 bias off", bias_en, 0);
    wait_until(c + 5);
    c = cyc; stby_n = 1'b1;
    push(3'd2, c + 1, "R10"); push(3'd3, c + 1 + DSU, "R10"); push(3'd4, c + 1 + DSU + DSS, "R10");
    wait_until(c + DSU);
    check("R10 full startup delay", mode_o, 2);
    wait_until(c + 4 + DSU + DSS);

    // standby in mid startup, then direct normal
    c = cyc; stby_n = 1'b0; boost_en = 1'b0; push(3'd1, c + 1, "R10");
    wait_until(c + 3);
    c = cyc; stby_n = 1'b1; push(3'd2, c + 1, "R10");
    wait_until(c + 20);
    c = cyc; stby_n = 1'b0; push(3'd1, c + 1, "R10");
    wait_until(c + 3);
    c = cyc; stby_n = 1'b1; push(3'd2, c + 1, "R9"); push(3'd4, c + 1 + DSU, "R9");
    wait_until(c + 1 + DSU);
    check("R9 converter off", boost_run, 0);
    check("R9 osc_ready", osc_ready, 1);
    wait_until(c + 4 + DSU);

    // boost disabled in mid soft-start
    c = cyc; boost_en = 1'b1; push(3'd3, c + 1, "R8");
    wait_until(c + 5);
    c = cyc; boost_en = 1'b0; push(3'd4, c + 1, "R7");
    wait_until(c + 1);
    check("R7 soft-start aborted", boost_run, 0);
    wait_until(c + 3);

    // power-on reset
    c = cyc; por_active = 1'b1; push(3'd0, c + 1, "R1");
    wait_until(c + 3);
    check("R1 por regs_reset", regs_reset, 1);
    check("R1 por bias off", bias_en, 0);
    c = cyc; por_active = 1'b0;
    push(3'd1, c + 1, "R1"); push(3'd2, c + 2, "R3"); push(3'd4, c + 2 + DSU, "R9");
    wait_until(c + 5 + DSU);

    // external reset
    c = cyc; rst_ext_n = 1'b0; push(3'd0, c + 1, "R1");
    wait_until(c + 2);
    check("R1 ext regs_reset", regs_reset, 1);
    check("R1 ext others off", {bias_en, osc_ready, boost_run, boost_pfm}, 0);
    c = cyc; stby_n = 1'b0; rst_ext_n = 1'b1; push(3'd1, c + 1, "R1");
    wait_until(c + 4);

    check("R1 all expected mode changes seen", q.size(), 0);
    mon_en = 1'b0;
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule